// File: doc/BRIEF.md
# Phase Gate Sequencer with Bootstrap Refresh

This block is the gate-timing logic for one half-bridge phase. It takes a single PWM command and produces two complementary gate enables, one for the high-side switch and one for the low-side switch. The two enables are never on together. Every handover between them passes through a fixed number of clock cycles in which both are off. The low-side enable, once on, stays on for a minimum number of cycles so that the floating high-side supply capacitor can recharge. When the PWM period is known, the block also shortens an over-long high command so that this minimum low pulse still ends before the next rising edge. As a result the effective duty cycle saturates just below 100%.

An asynchronous bootstrap-undervoltage flag is synchronised inside the block. While the flag is raised, high-side on-intervals are capped at a short dwell. Each one is followed by a dead gap and a full minimum low-side pulse, and the loop repeats until the flag drops. A high-impedance request from the protection logic turns both enables off in the same cycle, then restarts the sequence from a safe state. During reset both enables are off and a weak-pulldown enable is raised to precharge the bootstrap capacitor. Dead time, minimum low width, recharge dwell and counter width are parameters given in clock cycles.

Top module: `phase_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: Each time either enable turns on, both enables have been low for at least DEAD_CYC (default 3) consecutive cycles just before. In a normal handover the gap is exactly DEAD_CYC.
- R3: The high-side pulse starts DEAD_CYC cycles after the first clock edge that samples `pwm_in` high, and it ends at the first edge that samples it low. A high command of H cycles therefore gives a high-side pulse of H-DEAD_CYC cycles (for example P=40, H=15 gives 12 high and 22 low). While `pwm_in` stays high with no flag raised, `hs_en` stays on.
- R4: Each low-side pulse lasts at least MIN_LOW_CYC (default 6) cycles unless it is cut short by a high-impedance request. A PWM rise that arrives earlier holds the low side on until the minimum is met, and only then starts the dead gap toward the high side.
- R5: Once two rising edges of `pwm_in` have been seen, the period P between the last two is known. The high-side pulse is then capped at P-MIN_LOW_CYC-2*DEAD_CYC cycles, which leaves exactly MIN_LOW_CYC of low side before the next rise (P=40 with H=38 gives 28 high and 6 low; P=60 with H=58 gives 48 high).
- R6: While the synchronised `bst_uv` is high, high-side intervals last at most RCH_HS_CYC (default 5) cycles. Each is followed by DEAD_CYC off, MIN_LOW_CYC of low side and DEAD_CYC off, and this repeats. After the flag clears, the high side again stays on for as long as `pwm_in` is high.
- R7: A high `hiz_req` forces both enables low in the same cycle. After the request is released the block restarts with DEAD_CYC off cycles followed by a low-side pulse, before the high side is allowed.
- R8: While `rst_n` is low, both enables are low and `pulldown_en` is high. `pulldown_en` drops at the first edge with `rst_n` high. After release the low side comes on after exactly DEAD_CYC off cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the phase's hold-off input |
| pwm_in | input | 1 | PWM command, 1 requests the high side |
| bst_uv | input | 1 | Asynchronous bootstrap-undervoltage flag |
| hiz_req | input | 1 | High-impedance request from protection logic |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| pulldown_en | output | 1 | Weak output pulldown enable for bootstrap precharge |

## Verification
The bench targets the near-100% duty corner. A design that ignored the measured period would keep the high side on for the full command minus dead time and leave a low pulse far shorter than the minimum. It also drives a PWM rise straight after reset, where a design that handed over as soon as it saw the rise would leave the bootstrap uncharged with a truncated first low pulse. The high-impedance release and the reset release are both timed to the exact cycle, which exposes a restart that skips the dead gap or goes to the high side first. The bench holds the undervoltage flag against a steady high command: a broken loop either never releases the high side or never returns to it.

// File: rtl/gseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the phase gate sequencer.
package gseq_pkg;
    // Sequencer states: off, dead toward low, low on, dead toward high, high on.
    typedef enum logic [2:0] {
        GS_OFF   = 3'd0,
        GS_DT_LO = 3'd1,
        GS_LO    = 3'd2,
        GS_DT_HI = 3'd3,
        GS_HI    = 3'd4
    } gs_state_e;
endpackage

// File: rtl/gseq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for one asynchronous level.
// Assumes: the input is a slow level; a pulse shorter than a clock may be lost.
module gseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= d;
            end
        end else begin : g_chain
            // Shift the level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/gseq_period_meter.sv
`timescale 1ns/1ps
// Measures the PWM period between rising edges. While the phase counter is
// inside the last DEAD_CYC+MIN_LOW_CYC cycles of the expected period, it
// raises a truncation request so that the high side ends early.
// Assumes: a period that reaches the counter ceiling is treated as unknown.
module gseq_period_meter #(
    parameter int CNT_W       = 8,
    parameter int DEAD_CYC    = 3,
    parameter int MIN_LOW_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    output logic trunc_req
);
    localparam int RW      = CNT_W + 2;
    localparam int RESERVE = DEAD_CYC + MIN_LOW_CYC;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             pwm_prev;
    logic             rise;
    logic [CNT_W-1:0] ph_cnt;
    logic [CNT_W-1:0] period_q;
    logic             ph_vld;
    logic             per_vld;
    logic [RW-1:0]    reach;

    assign rise = pwm_in & ~pwm_prev;

    // Track cycles since the last rise and latch the period at each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_prev <= 1'b0;
            ph_cnt   <= '0;
            period_q <= '0;
            ph_vld   <= 1'b0;
            per_vld  <= 1'b0;
        end else begin
            pwm_prev <= pwm_in;
            if (rise) begin
                ph_cnt   <= CNT_W'(1);
                period_q <= ph_cnt;
                ph_vld   <= 1'b1;
                per_vld  <= ph_vld && (ph_cnt != CNT_MAX);
            end else if (ph_cnt != CNT_MAX) begin
                ph_cnt <= ph_cnt + CNT_W'(1);
            end
        end
    end

    // Request truncation inside the reserved tail of the expected period.
    always_comb begin
        reach     = RW'(ph_cnt) + RW'(RESERVE);
        trunc_req = per_vld && (reach >= RW'(period_q)) && (ph_cnt < period_q);
    end
endmodule

// File: rtl/gseq_recharge.sv
`timescale 1ns/1ps
// Bootstrap recharge control: synchronises the undervoltage flag and, while
// it is raised, cuts each high-side interval after RCH_HS_CYC cycles.
// Assumes: hs_on is the sequencer's high-side state, before any override.
module gseq_recharge #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RCH_HS_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bst_uv,
    input  logic hs_on,
    output logic rch_cut
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] DWELL_LT = CNT_W'(RCH_HS_CYC - 1);

    logic             uv_s;
    logic [CNT_W-1:0] dwell;

    gseq_sync #(.STAGES(SYNC_STAGES)) u_uv_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bst_uv),
        .q     (uv_s)
    );

    // Count consecutive cycles spent with the high side on.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dwell <= '0;
        else if (!hs_on)            dwell <= '0;
        else if (dwell != CNT_MAX)  dwell <= dwell + CNT_W'(1);
    end

    // Cut the high side once the dwell limit is reached under undervoltage.
    assign rch_cut = uv_s && hs_on && (dwell >= DWELL_LT);
endmodule

// File: rtl/gseq_fsm.sv
`timescale 1ns/1ps
// Gate sequencing state machine: dead gaps, minimum low width and high-side
// exits on PWM fall, truncation or recharge cut. A protection request sends
// it to the off state, from which it always restarts through the low side.
// Assumes: DEAD_CYC >= 1 and MIN_LOW_CYC >= 1.
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DEAD_CYC    = 3,
    parameter int MIN_LOW_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_in,
    input  logic      hiz_req,
    input  logic      trunc_req,
    input  logic      rch_cut,
    output gs_state_e state
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] ML_LAST = CNT_W'(MIN_LOW_CYC - 1);

    gs_state_e        st;
    gs_state_e        nxt;
    logic             clr;
    logic [CNT_W-1:0] cnt;

    // Next-state selection and counter restart.
    always_comb begin
        nxt = st;
        clr = 1'b0;
        if (hiz_req) begin
            nxt = GS_OFF;
            clr = 1'b1;
        end else begin
            unique case (st)
                GS_OFF: begin
                    nxt = GS_DT_LO;
                    clr = 1'b1;
                end
                GS_DT_LO: begin
                    if (cnt >= DT_LAST) begin
                        nxt = GS_LO;
                        clr = 1'b1;
                    end
                end
                GS_LO: begin
                    if ((cnt >= ML_LAST) && pwm_in) begin
                        nxt = GS_DT_HI;
                        clr = 1'b1;
                    end
                end
                GS_DT_HI: begin
                    if (!pwm_in) begin
                        nxt = GS_DT_LO;
                        clr = 1'b1;
                    end else if (cnt >= DT_LAST) begin
                        nxt = GS_HI;
                        clr = 1'b1;
                    end
                end
                GS_HI: begin
                    if (!pwm_in || trunc_req || rch_cut) begin
                        nxt = GS_DT_LO;
                        clr = 1'b1;
                    end
                end
                default: begin
                    nxt = GS_OFF;
                    clr = 1'b1;
                end
            endcase
        end
    end

    // State and dwell counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= GS_OFF;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (clr)                  cnt <= '0;
            else if (cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
        end
    end

    assign state = st;
endmodule

// File: rtl/phase_gate_seq.sv
`timescale 1ns/1ps
// Per-phase gate sequencer top. Joins the period meter, the recharge control
// and the state machine, applies the protection override to the gate enables
// and drives the precharge pulldown during reset.
// Assumes: rst_n and hiz_req are synchronous to clk; bst_uv may be asynchronous.
module phase_gate_seq
    import gseq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DEAD_CYC    = 3,
    parameter int MIN_LOW_CYC = 6,
    parameter int RCH_HS_CYC  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic bst_uv,
    input  logic hiz_req,
    output logic hs_en,
    output logic ls_en,
    output logic pulldown_en
);
    gs_state_e state;
    logic      trunc_req;
    logic      rch_cut;
    logic      hs_on;
    logic      pd_q;

    assign hs_on = (state == GS_HI);

    gseq_period_meter #(
        .CNT_W       (CNT_W),
        .DEAD_CYC    (DEAD_CYC),
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .trunc_req (trunc_req)
    );

    gseq_recharge #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES),
        .RCH_HS_CYC  (RCH_HS_CYC)
    ) u_rch (
        .clk     (clk),
        .rst_n   (rst_n),
        .bst_uv  (bst_uv),
        .hs_on   (hs_on),
        .rch_cut (rch_cut)
    );

    gseq_fsm #(
        .CNT_W       (CNT_W),
        .DEAD_CYC    (DEAD_CYC),
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .hiz_req   (hiz_req),
        .trunc_req (trunc_req),
        .rch_cut   (rch_cut),
        .state     (state)
    );

    // Precharge pulldown follows the reset level, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= 1'b1;
        else        pd_q <= 1'b0;
    end

    // Gate enables with the protection override applied without delay.
    assign hs_en       = hs_on && !hiz_req;
    assign ls_en       = (state == GS_LO) && !hiz_req;
    assign pulldown_en = pd_q;
endmodule

// File: rtl/gseq_checker.sv
`timescale 1ns/1ps
// Property checker for phase_gate_seq, attached by bind below.
// Keeps its own off-gap and low-run counters built from the output ports.
module gseq_checker #(
    parameter int DEAD_CYC    = 3,
    parameter int MIN_LOW_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic hiz_req,
    input logic hs_en,
    input logic ls_en,
    input logic pulldown_en
);
    localparam int CW = $clog2(DEAD_CYC + MIN_LOW_CYC + 2) + 1;
    localparam logic [CW-1:0] CMAX   = '1;
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);
    localparam logic [CW-1:0] MINL_V = CW'(MIN_LOW_CYC);

    logic [CW-1:0] gap;
    logic [CW-1:0] ls_run;

    // Count consecutive samples with both enables off.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap <= CMAX;
        else if (hs_en || ls_en)  gap <= '0;
        else if (gap != CMAX)     gap <= gap + CW'(1);
    end

    // Count consecutive samples with the low side on.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ls_run <= '0;
        else if (!ls_en)                  ls_run <= '0;
        else if (ls_run != CMAX)          ls_run <= ls_run + CW'(1);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en)); // R1

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_en || ls_en) && !$past(hs_en || ls_en)) |-> (gap >= DEAD_V)); // R2

    AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_en && $past(ls_en) && !hiz_req) |-> (ls_run >= MINL_V)); // R4

    AST_HIZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_req |=> (!hs_en && !ls_en)); // R7

    AST_PD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        pulldown_en |-> (!hs_en && !ls_en)); // R8
endmodule

bind phase_gate_seq gseq_checker #(
    .DEAD_CYC    (DEAD_CYC),
    .MIN_LOW_CYC (MIN_LOW_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hiz_req     (hiz_req),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .pulldown_en (pulldown_en)
);

// File: tb/tb_phase_gate_seq.sv
`timescale 1ns/1ps
module tb_phase_gate_seq;
    localparam int DEAD = 3;
    localparam int MINL = 6;
    localparam int RCHH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic bst_uv = 1'b0;
    logic hiz_req = 1'b0;
    logic hs_en, ls_en, pulldown_en;

    int checks = 0;
    int errors = 0;

    // PWM stimulus: 0 = low, 1 = periodic, 2 = held high
    int pmode = 0;
    int per = 40;
    int hi = 15;
    int ph = 0;

    // Output monitor state
    int hs_run = 0, ls_run = 0, gap_run = 0;
    int last_hs = 0, last_ls = 0, gap_b_hs = 0, gap_b_ls = 0;
    int overlap = 0;

    phase_gate_seq #(
        .CNT_W(8), .DEAD_CYC(DEAD), .MIN_LOW_CYC(MINL),
        .RCH_HS_CYC(RCHH), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .bst_uv(bst_uv),
        .hiz_req(hiz_req), .hs_en(hs_en), .ls_en(ls_en),
        .pulldown_en(pulldown_en)
    );

    always #4 clk = ~clk;

    // PWM driver, away from the sampling edge
    always @(negedge clk) begin
        if (pmode == 1) begin
            pwm_in = (ph < hi);
            ph = (ph + 1 >= per) ? 0 : ph + 1;
        end else begin
            pwm_in = (pmode == 2);
        end
    end

    // Pulse-width monitor sampled at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            hs_run = 0; ls_run = 0; gap_run = 0;
        end else begin
            if (hs_en && ls_en) overlap++;
            if (hs_en) begin
                if (hs_run == 0) gap_b_hs = gap_run;
                hs_run++;
            end else if (hs_run > 0) begin
                last_hs = hs_run; hs_run = 0;
            end
            if (ls_en) begin
                if (ls_run == 0) gap_b_ls = gap_run;
                ls_run++;
            end else if (ls_run > 0) begin
                last_ls = ls_run; ls_run = 0;
            end
            if (!hs_en && !ls_en) gap_run++;
            else gap_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #2;
        rst_n = 1'b0; pmode = 0; hiz_req = 1'b0; bst_uv = 1'b0; ph = 0;
        repeat (3) @(negedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    // R8: reset state and release ordering
    task automatic t_reset();
        int off;
        @(negedge clk); #2;
        rst_n = 1'b0; pmode = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!hs_en && !ls_en, "R8 enables off in reset", hs_en + ls_en, 0);
        chk(pulldown_en == 1'b1, "R8 pulldown in reset", pulldown_en, 1);
        #1;
        rst_n = 1'b1;
        off = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (i == 0) chk(pulldown_en == 1'b0, "R8 pulldown after release", pulldown_en, 0);
            if (ls_en) break;
            off++;
        end
        chk(off == DEAD, "R8 low side after dead gap", off, DEAD);
    endtask

    // R4: rise right after reset waits for the minimum low pulse
    task automatic t_early_rise();
        do_reset();
        pmode = 2;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (hs_en) break;
        end
        chk(last_ls == MINL, "R4 first low pulse width", last_ls, MINL);
        chk(gap_b_hs == DEAD, "R2 gap before high", gap_b_hs, DEAD);
    endtask

    // R3, R2: normal duty
    task automatic t_normal();
        do_reset();
        per = 40; hi = 15; ph = 0; pmode = 1;
        wait_n(200);
        chk(last_hs == 12, "R3 high width", last_hs, 12);
        chk(last_ls == 22, "R3 low width", last_ls, 22);
        chk(gap_b_hs == DEAD, "R2 gap low to high", gap_b_hs, DEAD);
        chk(gap_b_ls == DEAD, "R2 gap high to low", gap_b_ls, DEAD);
    endtask

    // R5: high duty truncation
    task automatic t_trunc();
        per = 40; hi = 38;
        wait_n(200);
        chk(last_hs == 28, "R5 capped high P40", last_hs, 28);
        chk(last_ls == MINL, "R5 min low kept P40", last_ls, MINL);
        per = 60; hi = 58;
        wait_n(300);
        chk(last_hs == 48, "R5 capped high P60", last_hs, 48);
    endtask

    // R7: protection override and restart
    task automatic t_hiz();
        int off;
        bit bad;
        do_reset();
        per = 40; hi = 15; ph = 0; pmode = 1;
        wait_n(100);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (hs_en) break;
        end
        hiz_req = 1'b1;
        #1;
        chk(!hs_en && !ls_en, "R7 same-cycle off", hs_en + ls_en, 0);
        bad = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            if (hs_en || ls_en) bad = 1'b1;
        end
        chk(!bad, "R7 held off", bad, 0);
        #1;
        hiz_req = 1'b0;
        off = 0;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (hs_en) bad = 1'b1;
            if (ls_en) break;
            off++;
        end
        chk(off == DEAD && !bad, "R7 restart via low side", off, DEAD);
    endtask

    // R6: recharge loop under undervoltage
    task automatic t_recharge();
        pmode = 2;
        wait_n(100);
        chk(hs_en == 1'b1, "R3 held high command", hs_en, 1);
        bst_uv = 1'b1;
        wait_n(60);
        chk(last_hs == RCHH, "R6 high dwell", last_hs, RCHH);
        chk(last_ls == MINL, "R6 recharge low", last_ls, MINL);
        chk(gap_b_hs == DEAD, "R6 gap in loop", gap_b_hs, DEAD);
        bst_uv = 1'b0;
        wait_n(50);
        chk(hs_en && hs_run >= 20, "R6 resume after clear", hs_run, 20);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_early_rise();
        t_normal();
        t_trunc();
        t_hiz();
        t_recharge();
        chk(overlap == 0, "R1 no overlap", overlap, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule